// File: doc/BRIEF.md
# Masked Multi-Slot Frame Buffer Sequencer

This block picks the memory destination of every captured video frame for a capture DMA engine. Software preloads up to `NUM_SLOTS` buffer base addresses and a mask with one enable bit per slot. When a frame begins, the sequencer moves on to the next enabled slot, always in ascending slot order. It then drives that slot's base address to the pixel writer and holds it steady for the whole frame.

Software cannot change the visiting order. It can only take a slot out of rotation by clearing that slot's mask bit, for example while the buffer is owned by user code, and put it back later by setting the bit again. A base address may be rewritten while capture runs. When a frame closes, the block records which slot it completed, pulses an interrupt and sets a sticky pending flag. The slot now in use is also reported. If a frame starts while no slot is enabled, the frame is dropped and a sticky overflow flag records the loss.

Top module: `fbuf_seq`

## Requirements
- R1: After reset the mask and the capture enable are clear, and `cur_idx`, `prev_idx`, `dma_addr`, `dma_valid`, `frame_irq`, `irq_pending` and `overflow` are all 0.
- R2: When `frame_start` is high at a clock edge, capture is enabled and at least one mask bit is set, the block does three things from the next cycle: it drives `dma_valid` high, it sets `cur_idx` to the chosen slot, and it sets `dma_addr` to that slot's base address.
- R3: The chosen slot is the lowest enabled slot whose index is above the slot of the last issued frame. If there is none, the search wraps to the lowest enabled slot. The first frame after reset searches from slot 0. Disabled slots never receive a frame.
- R4: When a frame starts with capture enabled and an all-zero mask, the frame is dropped. `dma_valid` goes low, `cur_idx` and `dma_addr` keep their values, and `overflow` is set. `overflow` stays set until it is cleared by writing 1 to control bit 2.
- R5: When `frame_end` is high while a frame is active (`dma_valid` high), three things follow. `frame_irq` is high for exactly the next cycle. `prev_idx` becomes the slot of the completed frame. `irq_pending` is set and `dma_valid` drops.
- R6: Writing 1 to control bit 1 clears `irq_pending`. If a frame completes in the same cycle, the flag stays set.
- R7: Writes to a base address or to the mask never change `dma_addr` during a frame. The new values are used from the next frame start. A frame start in the same cycle as a write still uses the old values.
- R8: Register select `0..NUM_SLOTS-1` writes the base address of that slot. Select `NUM_SLOTS` writes the mask, where bit n enables slot n. Select `NUM_SLOTS+1` writes control: bit 0 is capture enable, bit 1 clears pending and bit 2 clears overflow. While capture enable is 0, `frame_start` is ignored.
- R9: `frame_end` with no active frame produces no interrupt and leaves `prev_idx` unchanged.
- R10: When `frame_end` and `frame_start` coincide, the ending frame completes (R5) and the new frame is issued (R2) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select |
| wr_data | input | ADDR_W | Register write data |
| frame_start | input | 1 | Frame start strobe from the video side |
| frame_end | input | 1 | Frame end strobe from the video side |
| dma_addr | output | ADDR_W | Base address of the frame being written |
| dma_valid | output | 1 | A frame is active and `dma_addr` is its destination |
| cur_idx | output | IDX_W | Slot of the frame currently in use |
| prev_idx | output | IDX_W | Slot of the frame completed last |
| frame_irq | output | 1 | One-cycle pulse per completed frame |
| irq_pending | output | 1 | Sticky completion flag |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
All results are registered once at the edge that samples the strobe or the write. `dma_addr`, `dma_valid` and `cur_idx` follow a frame start by one cycle. `frame_irq`, `prev_idx` and `irq_pending` follow a frame end by one cycle. A register write can first influence a frame start that is sampled one edge later. The bench drives each stimulus after a falling edge and advances its behavioural model at the next rising edge. It compares every output at the following falling edge, which places each comparison exactly in the first cycle where the result is due. Directed checks read the outputs at the same point, right after the cycle that carried the strobe.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  // control register bit positions
  localparam int CTRL_EN_BIT      = 0;
  localparam int CTRL_CLR_IRQ_BIT = 1;
  localparam int CTRL_CLR_OVF_BIT = 2;

  // width of a slot index, never below one bit
  function automatic int idx_width(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction
endpackage

// File: rtl/fbs_regs.sv
module fbs_regs
  import fbs_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [ADDR_W-1:0]                wr_data,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0] base_q,
  output logic [NUM_SLOTS-1:0]             mask_q,
  output logic                             cap_en,
  output logic                             mask_wr,
  output logic                             clr_pend,
  output logic                             clr_ovf
);
  localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'(NUM_SLOTS);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_SLOTS + 1);

  logic ctrl_wr;
  assign mask_wr  = wr_en && (wr_sel == SEL_MASK);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign clr_pend = ctrl_wr && wr_data[CTRL_CLR_IRQ_BIT];
  assign clr_ovf  = ctrl_wr && wr_data[CTRL_CLR_OVF_BIT];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  base_q[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))     base_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cap_en <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wr_data[NUM_SLOTS-1:0];
      if (ctrl_wr) cap_en <= wr_data[CTRL_EN_BIT];
    end
  end
endmodule

// File: rtl/fbs_pick.sv
module fbs_pick #(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_SLOTS-1:0] mask,
  input  logic [IDX_W-1:0]     from_idx,
  output logic                 hit,
  output logic [IDX_W-1:0]     pick_idx
);
  // {found, index} of the lowest set bit
  function automatic logic [IDX_W:0] lowest_set(input logic [NUM_SLOTS-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  logic [NUM_SLOTS-1:0] upper;
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_upper
    assign upper[g] = mask[g] && (IDX_W'(g) >= from_idx);
  end

  logic [IDX_W:0] up_res, all_res;
  assign up_res  = lowest_set(upper);
  assign all_res = lowest_set(mask);

  assign hit      = all_res[IDX_W];
  assign pick_idx = up_res[IDX_W] ? up_res[IDX_W-1:0] : all_res[IDX_W-1:0];
endmodule

// File: rtl/fbs_track.sv
module fbs_track #(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_evt,
  input  logic              drop_evt,
  input  logic              done_evt,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [ADDR_W-1:0] pick_addr,
  input  logic              clr_pend,
  input  logic              clr_ovf,
  output logic [IDX_W-1:0]  search_idx,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dma_valid,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  prev_idx,
  output logic              frame_irq,
  output logic              irq_pending,
  output logic              overflow
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      search_idx  <= '0;
      dma_addr    <= '0;
      dma_valid   <= 1'b0;
      cur_idx     <= '0;
      prev_idx    <= '0;
      frame_irq   <= 1'b0;
      irq_pending <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      frame_irq <= done_evt;
      if (done_evt) begin
        prev_idx    <= cur_idx;
        irq_pending <= 1'b1;
        dma_valid   <= 1'b0;
      end else if (clr_pend) begin
        irq_pending <= 1'b0;
      end
      if (clr_ovf) overflow <= 1'b0;
      if (issue_evt) begin
        dma_valid  <= 1'b1;
        dma_addr   <= pick_addr;
        cur_idx    <= pick_idx;
        search_idx <= after(pick_idx);
      end else if (drop_evt) begin
        dma_valid <= 1'b0;
        overflow  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbuf_seq.sv
module fbuf_seq
  import fbs_pkg::*;
#(
  parameter int  NUM_SLOTS = 32,
  parameter int  ADDR_W    = 32,
  localparam int IDX_W     = idx_width(NUM_SLOTS),
  localparam int SEL_W     = $clog2(NUM_SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dma_valid,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  prev_idx,
  output logic              frame_irq,
  output logic              irq_pending,
  output logic              overflow
);
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] base_q;
  logic [NUM_SLOTS-1:0]             mask_q;
  logic                             cap_en, mask_wr, clr_pend, clr_ovf;
  logic                             hit;
  logic [IDX_W-1:0]                 pick_idx, search_idx;
  logic [ADDR_W-1:0]                pick_addr;

  // named events
  logic issue_evt, drop_evt, done_evt;
  assign issue_evt = frame_start && cap_en && hit;
  assign drop_evt  = frame_start && cap_en && !hit;
  assign done_evt  = frame_end && dma_valid;
  assign pick_addr = base_q[pick_idx];

  fbs_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base_q(base_q), .mask_q(mask_q), .cap_en(cap_en), .mask_wr(mask_wr),
    .clr_pend(clr_pend), .clr_ovf(clr_ovf)
  );

  fbs_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .mask(mask_q), .from_idx(search_idx), .hit(hit), .pick_idx(pick_idx)
  );

  fbs_track #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .issue_evt(issue_evt), .drop_evt(drop_evt),
    .done_evt(done_evt), .pick_idx(pick_idx), .pick_addr(pick_addr),
    .clr_pend(clr_pend), .clr_ovf(clr_ovf), .search_idx(search_idx),
    .dma_addr(dma_addr), .dma_valid(dma_valid), .cur_idx(cur_idx),
    .prev_idx(prev_idx), .frame_irq(frame_irq), .irq_pending(irq_pending),
    .overflow(overflow)
  );
endmodule

// File: rtl/fbuf_seq_chk.sv
module fbuf_seq_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_start,
  input logic                 frame_end,
  input logic                 cap_en,
  input logic [NUM_SLOTS-1:0] mask_q,
  input logic                 mask_wr,
  input logic                 clr_ovf,
  input logic [ADDR_W-1:0]    dma_addr,
  input logic                 dma_valid,
  input logic [IDX_W-1:0]     cur_idx,
  input logic                 frame_irq,
  input logic                 irq_pending,
  input logic                 overflow
);
  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cap_en && (|mask_q)) |=> dma_valid);

  a_r3_enabled_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cap_en && (|mask_q) && !mask_wr) |=> mask_q[cur_idx]);

  a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cap_en && (mask_q == '0)) |=> (!dma_valid && overflow));

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && cap_en) |=> $stable(dma_addr));

  a_r5_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> irq_pending);

  a_r9_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !dma_valid) |=> !frame_irq);

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !dma_valid) |=> !dma_valid);
endmodule

bind fbuf_seq fbuf_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
  .cap_en(cap_en), .mask_q(mask_q), .mask_wr(mask_wr), .clr_ovf(clr_ovf),
  .dma_addr(dma_addr), .dma_valid(dma_valid), .cur_idx(cur_idx),
  .frame_irq(frame_irq), .irq_pending(irq_pending), .overflow(overflow)
);

// File: tb/fbuf_seq_test.sv
`timescale 1ns/1ps
module fbuf_seq_test;
  localparam int N    = 32;
  localparam int AW   = 32;
  localparam int SELW = $clog2(N + 2);
  localparam int IW   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SELW-1:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic frame_start = 1'b0, frame_end = 1'b0;
  logic [AW-1:0] dma_addr;
  logic dma_valid, frame_irq, irq_pending, overflow;
  logic [IW-1:0] cur_idx, prev_idx;

  always #2.5 clk = ~clk;

  fbuf_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_start(frame_start), .frame_end(frame_end), .dma_addr(dma_addr),
    .dma_valid(dma_valid), .cur_idx(cur_idx), .prev_idx(prev_idx),
    .frame_irq(frame_irq), .irq_pending(irq_pending), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [AW-1:0] m_base [N];
  logic [N-1:0]  m_mask;
  bit            m_en, m_valid, m_irq, m_pend, m_ovf;
  int            m_cur, m_prev, m_next;
  logic [AW-1:0] m_addr;

  function automatic logic [AW-1:0] base_of(int i);
    return 32'h8000_0000 + i * 32'h100;
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_base[i]) m_base[i] = '0;
    m_mask = '0; m_en = 0; m_valid = 0; m_irq = 0; m_pend = 0; m_ovf = 0;
    m_cur = 0; m_prev = 0; m_next = 0; m_addr = '0;
  endtask

  // model advance at a rising edge, from the inputs held before it
  task automatic model_edge();
    bit wr_ctrl, found;
    int slot;
    wr_ctrl = wr_en && (wr_sel == SELW'(N + 1));
    m_irq = 0;
    if (frame_end && m_valid) begin
      m_prev = m_cur; m_irq = 1; m_pend = 1; m_valid = 0;
    end else if (wr_ctrl && wr_data[1]) m_pend = 0;
    if (wr_ctrl && wr_data[2]) m_ovf = 0;
    if (frame_start && m_en) begin
      found = 0; slot = 0;
      for (int k = 0; k < N; k++)
        if (!found && m_mask[(m_next + k) % N]) begin found = 1; slot = (m_next + k) % N; end
      if (found) begin
        m_valid = 1; m_cur = slot; m_addr = m_base[slot]; m_next = (slot + 1) % N;
      end else begin
        m_valid = 0; m_ovf = 1;
      end
    end
    if (wr_en) begin
      if (int'(wr_sel) < N)       m_base[wr_sel] = wr_data;
      else if (int'(wr_sel) == N) m_mask = wr_data[N-1:0];
      else if (wr_ctrl)           m_en = wr_data[0];
    end
  endtask

  task automatic compare_all();
    check("R2 dma_valid", AW'(dma_valid), AW'(m_valid));
    check("R2 dma_addr", dma_addr, m_addr);
    check("R3 cur_idx", AW'(cur_idx), AW'(m_cur));
    check("R5 prev_idx", AW'(prev_idx), AW'(m_prev));
    check("R5 frame_irq", AW'(frame_irq), AW'(m_irq));
    check("R6 irq_pending", AW'(irq_pending), AW'(m_pend));
    check("R4 overflow", AW'(overflow), AW'(m_ovf));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    wr_en = 0; frame_start = 0; frame_end = 0;
  endtask

  task automatic wr(int sel, logic [AW-1:0] d);
    wr_en = 1; wr_sel = SELW'(sel); wr_data = d; step();
  endtask
  task automatic fs(); frame_start = 1; step(); endtask
  task automatic fe(); frame_end = 1; step(); endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 dma_valid", AW'(dma_valid), 0);
    check("R1 cur_idx", AW'(cur_idx), 0);
    check("R1 prev_idx", AW'(prev_idx), 0);
    check("R1 flags", AW'({frame_irq, irq_pending, overflow}), 0);
    check("R1 dma_addr", dma_addr, 0);
    fs();
    check("R8 start ignored while disabled", AW'(dma_valid), 0);

    for (int i = 0; i < N; i++) wr(i, base_of(i));
    wr(N, 32'h4000_0022);
    wr(N + 1, 32'h1);
    // R3 ascending walk and wrap
    fs(); check("R3 first slot", AW'(cur_idx), 1); check("R2 addr", dma_addr, base_of(1)); fe();
    check("R5 prev after end", AW'(prev_idx), 1);
    fs(); check("R3 skip to 5", AW'(cur_idx), 5); fe();
    fs(); check("R3 slot 30", AW'(cur_idx), 30); fe();
    fs(); check("R3 wrap to 1", AW'(cur_idx), 1); fe();
    fs(); check("R3 slot 5 again", AW'(cur_idx), 5);
    // R7 mid-frame rewrites
    wr(5, 32'hDEAD_0000);
    wr(N, 32'h0000_0022);
    check("R7 addr held mid-frame", dma_addr, base_of(5));
    fe();
    fs(); check("R7 masked slot skipped", AW'(cur_idx), 1); fe();
    fs(); check("R7 new base used", dma_addr, 32'hDEAD_0000); fe();
    // R10 coincident end and start
    fs();
    frame_end = 1; frame_start = 1; step();
    check("R10 irq", AW'(frame_irq), 1);
    check("R10 prev", AW'(prev_idx), 1);
    check("R10 new slot", AW'(cur_idx), 5);
    check("R10 valid", AW'(dma_valid), 1);
    fe();
    // R9 end without frame
    fe();
    check("R9 no irq", AW'(frame_irq), 0);
    check("R9 prev kept", AW'(prev_idx), 5);
    // R6 pending clear, and set winning over clear
    wr(N + 1, 32'h3);
    check("R6 cleared", AW'(irq_pending), 0);
    fs();
    frame_end = 1; wr(N + 1, 32'h3);
    check("R6 set wins", AW'(irq_pending), 1);
    // R4 empty mask
    wr(N, 32'h0);
    fs();
    check("R4 overflow set", AW'(overflow), 1);
    check("R4 no address", AW'(dma_valid), 0);
    check("R4 cur kept", AW'(cur_idx), 1);
    step();
    check("R4 sticky", AW'(overflow), 1);
    wr(N + 1, 32'h5);
    check("R4 cleared", AW'(overflow), 0);
    // R8 disable
    wr(N, 32'h22);
    wr(N + 1, 32'h0);
    fs(); check("R8 disabled start", AW'(dma_valid), 0);
    wr(N + 1, 32'h1);
    fs(); check("R8 re-enabled", AW'(cur_idx), 5); fe();

    // pseudo-random traffic against the model
    begin
      logic [31:0] lfsr = 32'hACE1_2345;
      for (int c = 0; c < 3000; c++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        frame_start = (lfsr[3:0] == 4'h1);
        frame_end   = (lfsr[7:4] == 4'h2);
        if (lfsr[12:9] == 4'h7) begin
          wr_en = 1;
          case (lfsr[15:13])
            3'd0:    begin wr_sel = SELW'(N);     wr_data = {lfsr[20:5], lfsr[31:16]} & {8'hFF, lfsr[23:0]}; end
            3'd1:    begin wr_sel = SELW'(N + 1); wr_data = {29'd0, lfsr[18:17], 1'b1}; end
            3'd2:    begin wr_sel = SELW'(N);     wr_data = 32'h0; end
            default: begin wr_sel = SELW'(lfsr[20:16]); wr_data = lfsr; end
          endcase
        end
        step();
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule